// File: doc/BRIEF.md
# Instruction Block Signature Checker

This block folds the instruction words of one fetched cache block into a keyed signature and compares the result with a reference signature that arrives alongside the block. Words enter one per cycle on a valid/data pair. They pass through a multiple-input shift register with fixed linear feedback. The register is seeded from a key input at the first word of every block. Any block of identical code under the same key therefore yields the same signature, whether it is computed at install time or at fetch time.

When the last word of a block has been absorbed, the block raises a one-cycle done pulse and a match flag. The flag tells the fetch path whether the block may be trusted. The reference arrives in plain form, and the block holds no key of its own: the key seed is supplied on a port.

Top module: `ibsig_check`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, done and match are 0, and the word count starts at zero.
- R2: Signature step: with s the register width, each accepted word w (zero-extended to s bits) maps the state x to (x << 1) ^ (x[msb] ? POLY : 0) ^ w. POLY is a primitive polynomial, default x^32+x^22+x^2+x+1, written 32'h0040_0007. The base for the first word of a block is key_seed; for later words it is the previous state.
- R3: If the folded signature equals ref_sig, match is 1 during the done pulse. If it differs in any bit, match is 0.
- R4: done is high for exactly one cycle. That cycle follows the clock edge that accepts the BLK_WORDS-th valid word of a block, and done is low at every other time.
- R5: A cycle with in_valid low neither advances the word count nor changes the signature. in_word is ignored in such a cycle.
- R6: Each block restarts from key_seed. Two consecutive blocks with the same words and key give the same verdict, and nothing carries over from one to the next.
- R7: match is 0 whenever done is 0.
- R8: ref_sig is sampled only on the edge that accepts the last word of a block. Its value at any other time has no effect.
- R9: key_seed is sampled only on the edge that accepts the first word of a block. Later changes within the block have no effect.
- R10: Blocks may follow each other with no idle cycle. The done pulse of one block coincides with the cycle in which the next block's first word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_seed | input | SIG_W | Key the register is loaded from at a block's first word |
| in_valid | input | 1 | Qualifies in_word for this cycle |
| in_word | input | WORD_W | Instruction word |
| ref_sig | input | SIG_W | Reference signature, sampled with the last word |
| done | output | 1 | One-cycle pulse after the last word of a block |
| match | output | 1 | Computed signature equals reference; valid while done |

## Verification
The verdict has one register stage. done and match are due in the cycle right after the edge that takes the last valid word, and they fall in the following cycle. The bench drives and samples on the falling edge. It reads done and match at the first falling edge after the last word is driven, expects both low one falling edge later, and expects done low at every falling edge inside a block, including gap cycles. Expected signatures come from a model of R2 in the bench. The scenarios vary gaps, back-to-back blocks, a corrupted reference, and key or reference values that change outside their sampling edges.

// File: rtl/ibsig_pkg.sv
package ibsig_pkg;
  // Primitive feedback polynomial x^32+x^22+x^2+x+1 (x^32 term implicit)
  localparam logic [31:0] DEF_POLY = 32'h0040_0007;

  typedef struct packed {
    logic done;
    logic match;
  } verdict_t;
endpackage

// File: rtl/ibsig_ctr.sv
module ibsig_ctr #(
  parameter int BLK_WORDS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic first_o,
  output logic last_acc_o
);
  localparam int CNT_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_WORDS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last    = (cnt_q == LAST_IDX);
  assign first_o    = (cnt_q == '0);
  assign last_acc_o = in_valid && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ibsig_misr.sv
module ibsig_misr #(
  parameter int          WORD_W = 32,
  parameter int          SIG_W  = 32,
  parameter logic [SIG_W-1:0] POLY = SIG_W'(ibsig_pkg::DEF_POLY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              first_i,
  input  logic [WORD_W-1:0] in_word,
  input  logic [SIG_W-1:0]  key_seed,
  output logic [SIG_W-1:0]  sig_next_o
);
  logic [SIG_W-1:0] state_q, base, word_ext, fb_term;

  always_comb begin
    word_ext = '0;
    word_ext[WORD_W-1:0] = in_word;
  end

  // reseed at the first word of a block so nothing survives between blocks
  assign base       = first_i ? key_seed : state_q;
  assign fb_term    = base[SIG_W-1] ? POLY : '0;
  assign sig_next_o = {base[SIG_W-2:0], 1'b0} ^ fb_term ^ word_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (in_valid) state_q <= sig_next_o;
  end
endmodule

// File: rtl/ibsig_cmp.sv
module ibsig_cmp #(
  parameter int SIG_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                last_acc_i,
  input  logic [SIG_W-1:0]    sig_next_i,
  input  logic [SIG_W-1:0]    ref_sig,
  output ibsig_pkg::verdict_t verdict_o
);
  ibsig_pkg::verdict_t v_q, v_d;

  always_comb begin
    v_d.done  = last_acc_i;
    v_d.match = last_acc_i && (sig_next_i == ref_sig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  assign verdict_o = v_q;
endmodule

// File: rtl/ibsig_check.sv
module ibsig_check #(
  parameter int WORD_W    = 32,
  parameter int SIG_W     = 32,
  parameter int BLK_WORDS = 8,
  parameter logic [SIG_W-1:0] POLY = SIG_W'(ibsig_pkg::DEF_POLY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIG_W-1:0]  key_seed,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [SIG_W-1:0]  ref_sig,
  output logic              done,
  output logic              match
);
  logic                first_w, last_acc_w;
  logic [SIG_W-1:0]    sig_next_w;
  ibsig_pkg::verdict_t verdict_w;

  ibsig_ctr #(.BLK_WORDS(BLK_WORDS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .first_o(first_w), .last_acc_o(last_acc_w)
  );

  ibsig_misr #(.WORD_W(WORD_W), .SIG_W(SIG_W), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_i(first_w),
    .in_word(in_word), .key_seed(key_seed), .sig_next_o(sig_next_w)
  );

  ibsig_cmp #(.SIG_W(SIG_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .last_acc_i(last_acc_w),
    .sig_next_i(sig_next_w), .ref_sig(ref_sig), .verdict_o(verdict_w)
  );

  assign done  = verdict_w.done;
  assign match = verdict_w.match;
endmodule

// File: rtl/ibsig_check_sva.sv
module ibsig_check_sva #(
  parameter int BLK_WORDS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic done,
  input logic match
);
  localparam int CW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  logic [CW-1:0] seen_q;
  logic          end_blk;

  assign end_blk = in_valid && (seen_q == CW'(BLK_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (in_valid) seen_q <= end_blk ? '0 : seen_q + 1'b1;
  end

  // R7: verdict flag only while done
  p_match_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !match);
  // R4: done follows the block's final accepted word
  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_blk |=> done);
  // R4: no done without a block end
  p_no_spurious_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !end_blk |=> !done);
  // R5: an idle cycle never completes a block
  p_idle_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  // R4: pulse width of one cycle (BLK_WORDS >= 2)
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ibsig_check ibsig_check_sva #(.BLK_WORDS(BLK_WORDS)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .done(done), .match(match)
);

// File: tb/tb_ibsig_check.sv
module tb_ibsig_check;
  localparam int BLK = 8;
  localparam logic [31:0] POLY = 32'h0040_0007;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] key_seed, in_word, ref_sig;
  logic        in_valid;
  logic        done, match;

  int checks = 0;
  int errors = 0;
  logic [31:0] w [BLK];

  ibsig_check dut (
    .clk(clk), .rst_n(rst_n), .key_seed(key_seed), .in_valid(in_valid),
    .in_word(in_word), .ref_sig(ref_sig), .done(done), .match(match)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] fold(input logic [31:0] key);
    logic [31:0] s = key;
    for (int i = 0; i < BLK; i++)
      s = {s[30:0], 1'b0} ^ (s[31] ? POLY : 32'h0) ^ w[i];
    return s;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < BLK; i++) w[i] = 32'h9E37_79B9 * (seed + i) ^ (i << 7);
  endtask

  // one block; gap: idle cycles between words; bad: corrupt ref;
  // disturb: wrong key/ref outside their sampling edges
  task automatic run_block(input logic [31:0] key, input bit gap, input bit bad,
                           input bit disturb, input string req);
    logic [31:0] exp = fold(key);
    for (int i = 0; i < BLK; i++) begin
      @(negedge clk);
      if (i > 0) chk(done == 1'b0, "R4", done, 0);
      in_valid = 1'b1;
      in_word  = w[i];
      key_seed = (disturb && i > 0) ? ~key : key;
      if (disturb && i != BLK - 1) ref_sig = ~exp;
      else                         ref_sig = bad ? (exp ^ 32'h1) : exp;
      if (gap && i < BLK - 1) begin
        @(negedge clk);
        chk(done == 1'b0, "R5", done, 0);
        in_valid = 1'b0;
        in_word  = ~w[i];
        ref_sig  = ~exp;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b1, "R4", done, 1);
    chk(match == !bad, req, match, !bad);
    @(negedge clk);
    chk(done == 1'b0, "R4", done, 0);
    chk(match == 1'b0, "R7", match, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; key_seed = '0; ref_sig = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", done, 0);
    chk(match == 1'b0, "R1", match, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && match == 1'b0, "R1", {done, match}, 0);
  endtask

  // R6 R10: two identical blocks back to back, no idle cycle
  task automatic t_back_to_back(input logic [31:0] key);
    logic [31:0] exp = fold(key);
    for (int j = 0; j < 2 * BLK; j++) begin
      @(negedge clk);
      if (j == BLK) begin
        chk(done == 1'b1, "R10", done, 1);
        chk(match == 1'b1, "R6", match, 1);
      end else if (j > 0) begin
        chk(done == 1'b0, "R10", done, 0);
      end
      in_valid = 1'b1; in_word = w[j % BLK]; key_seed = key; ref_sig = exp;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b1, "R10", done, 1);
    chk(match == 1'b1, "R6", match, 1);
    @(negedge clk);
    chk(done == 1'b0, "R4", done, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    fill(1);  run_block(32'hA5A5_1234, 0, 0, 0, "R2");
    fill(2);  run_block(32'h0000_0001, 0, 1, 0, "R3");
    fill(3);  run_block(32'hFFFF_FFFF, 1, 0, 0, "R5");
    fill(4);  run_block(32'h1357_9BDF, 0, 0, 1, "R8");
    fill(5);  run_block(32'hC0DE_0042, 1, 0, 1, "R9");
    fill(6);  run_block(32'h8000_0000, 0, 1, 1, "R3");
    fill(7);  t_back_to_back(32'h2468_ACE0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule